// File: doc/BRIEF.md
# One-Wire Bus Reset and Presence Detector

This block runs the reset phase of a single-wire, open-drain bus and reports what it saw. A one-cycle start request while the block is idle makes it drive the line low for the reset period. It then lets the line go and checks the line a fixed time after release to see whether a slave pulled it low to signal its presence. After that it waits until the release window ends and checks the line once more. A line that is still low at that point means the bus is shorted or held low, and the block reports this as a separate error.

Time is counted in microseconds. A prescaler divides the system clock by `CLK_PER_US` to make the microsecond tick. The prescaler restarts on every accepted start, so each phase lasts an exact number of clock cycles. The bus is modelled as a drive-low enable and a line input, and the line input passes through a two-flop synchronizer. When `USE_PULLUP` is set, an optional weak pull-up enable is turned on whenever the block is not driving the line. The results stay readable after the sequence finishes. A caller pulses start, waits for the done pulse, and then reads the presence and short flags. The flags keep their values until the next start. This block has no data stream, so every pin is a plain control or status pin.

Top module: `ow_reset_ctrl`

## Requirements
- R1: A start seen in an idle cycle makes `bus_drive_low` and `busy` high from the next cycle. `bus_drive_low` stays high for exactly `RST_LOW_US*CLK_PER_US` cycles.
- R2: `pullup_en` is 0 whenever `bus_drive_low` is 1. With `USE_PULLUP=1`, `pullup_en` is 1 in every cycle where the line is not driven, which covers idle and the release window.
- R3: `presence` reads 1 only if the synchronized line was low at the end of microsecond `SAMPLE_US` after release. A pulse that ends before that point, or starts after it, gives `presence`=0.
- R4: `bus_short` reads 1 only if the synchronized line is still low at the end of the release window, which is `WINDOW_US` microseconds after release.
- R5: `busy` stays high for exactly `(RST_LOW_US+WINDOW_US)*CLK_PER_US` cycles. `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R6: From the done pulse until the next accepted start, `presence` and `bus_short` hold their values, whatever the line does.
- R7: A start while `busy` is high is ignored. It changes neither the sequence length nor the drive period.
- R8: An accepted start clears `presence` and `bus_short` in the next cycle.
- R9: After reset the block is idle: `busy`, `done`, `bus_drive_low`, `presence` and `bus_short` are 0, and `pullup_en` equals `USE_PULLUP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a reset sequence; acted on only while idle |
| bus_in | input | 1 | Bus line level (1 = released high) |
| bus_drive_low | output | 1 | 1 = pull the bus line low |
| pullup_en | output | 1 | 1 = enable the weak internal pull-up |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence finishes |
| presence | output | 1 | A slave answered in the last sequence |
| bus_short | output | 1 | Line was still low at the end of the last window |

## Verification
A wrong prescaler or microsecond counter would not stay hidden. It shows at the ports in the very first sequence, because the drive-low period and the busy length are measured in cycles and compared with exact counts. If the sample point has slipped, the presence result flips only for pulses whose edges lie close to that point. The bench therefore uses pulses that end just before the sample point, start just after it, and end just after the window. A corrupted state register is caught within one cycle by the bound properties on drive exclusivity, on the done pulse and on flag stability, or at the next done pulse by the result checks.

// File: rtl/ow_rst_pkg.sv
package ow_rst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_RELEASE = 2'd2
  } ow_state_e;
endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLK_PER_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST) && !clr;
endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_in};
    end
  end

  assign line_q = pipe_q[STAGES-1];
endmodule

// File: rtl/ow_rst_seq.sv
module ow_rst_seq
  import ow_rst_pkg::*;
#(
  parameter int RST_LOW_US = 480,
  parameter int SAMPLE_US  = 64,
  parameter int WINDOW_US  = 480
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      tick,
  input  logic      line_hi,
  output ow_state_e state,
  output logic      accept,
  output logic      done,
  output logic      presence,
  output logic      bus_short
);
  localparam int MAXUS = (RST_LOW_US > WINDOW_US) ? RST_LOW_US : WINDOW_US;
  localparam int CW    = $clog2(MAXUS + 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(RST_LOW_US - 1);
  localparam logic [CW-1:0] SMP_LAST = CW'(SAMPLE_US - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW_US - 1);

  ow_state_e     st_q;
  logic [CW-1:0] us_q;
  logic          seen_q;

  assign accept = (st_q == ST_IDLE) && start;
  assign state  = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      us_q      <= '0;
      seen_q    <= 1'b0;
      done      <= 1'b0;
      presence  <= 1'b0;
      bus_short <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q      <= ST_DRIVE;
            us_q      <= '0;
            seen_q    <= 1'b0;
            presence  <= 1'b0;
            bus_short <= 1'b0;
          end
        end
        ST_DRIVE: begin
          if (tick) begin
            if (us_q == LOW_LAST) begin
              st_q <= ST_RELEASE;
              us_q <= '0;
            end else begin
              us_q <= us_q + 1'b1;
            end
          end
        end
        ST_RELEASE: begin
          if (tick) begin
            if (us_q == SMP_LAST) begin
              seen_q <= !line_hi;
            end
            if (us_q == WIN_LAST) begin
              st_q      <= ST_IDLE;
              us_q      <= '0;
              done      <= 1'b1;
              presence  <= (us_q == SMP_LAST) ? !line_hi : seen_q;
              bus_short <= !line_hi;
            end else begin
              us_q <= us_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_reset_ctrl.sv
module ow_reset_ctrl
  import ow_rst_pkg::*;
#(
  parameter int CLK_PER_US = 10,
  parameter int RST_LOW_US = 480,
  parameter int SAMPLE_US  = 64,
  parameter int WINDOW_US  = 480,
  parameter bit USE_PULLUP = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_in,
  output logic bus_drive_low,
  output logic pullup_en,
  output logic busy,
  output logic done,
  output logic presence,
  output logic bus_short
);
  ow_state_e st;
  logic      tick;
  logic      line_hi;
  logic      accept;

  ow_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .tick (tick)
  );

  ow_line_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_in(bus_in),
    .line_q (line_hi)
  );

  ow_rst_seq #(
    .RST_LOW_US(RST_LOW_US),
    .SAMPLE_US (SAMPLE_US),
    .WINDOW_US (WINDOW_US)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (tick),
    .line_hi  (line_hi),
    .state    (st),
    .accept   (accept),
    .done     (done),
    .presence (presence),
    .bus_short(bus_short)
  );

  assign bus_drive_low = (st == ST_DRIVE);
  assign busy          = (st != ST_IDLE);

  generate
    if (USE_PULLUP) begin : g_pullup
      assign pullup_en = (st != ST_DRIVE);
    end else begin : g_no_pullup
      assign pullup_en = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ow_reset_ctrl_chk.sv
module ow_reset_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic bus_drive_low,
  input logic pullup_en,
  input logic busy,
  input logic done,
  input logic presence,
  input logic bus_short
);
  a_r2_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_drive_low && pullup_en));

  a_r1_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (bus_drive_low && busy));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_no_redrive: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_drive_low) |=> !bus_drive_low);

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(presence) && $stable(bus_short)));

  a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (!presence && !bus_short));
endmodule

bind ow_reset_ctrl ow_reset_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .bus_drive_low(bus_drive_low),
  .pullup_en    (pullup_en),
  .busy         (busy),
  .done         (done),
  .presence     (presence),
  .bus_short    (bus_short)
);

// File: tb/tb_ow_reset_ctrl.sv
module tb_ow_reset_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 2;
  localparam int LOWU = 480;
  localparam int SMPU = 64;
  localparam int WINU = 480;
  localparam int LOW_CYC  = LOWU * CPU;
  localparam int BUSY_CYC = (LOWU + WINU) * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bus_in;
  logic bus_drive_low, pullup_en, busy, done, presence, bus_short;

  int n_cmp = 0;
  int n_bad = 0;

  int ps = 0, pe = 0;
  logic force_low = 1'b0;
  int rel_cnt = 0;
  logic slave_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_reset_ctrl #(
    .CLK_PER_US(CPU), .RST_LOW_US(LOWU), .SAMPLE_US(SMPU),
    .WINDOW_US(WINU), .USE_PULLUP(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_in(bus_in),
    .bus_drive_low(bus_drive_low), .pullup_en(pullup_en), .busy(busy),
    .done(done), .presence(presence), .bus_short(bus_short)
  );

  // Slave model: counts cycles since release and pulls low within [ps, pe)
  always @(posedge clk) begin
    if (busy && !bus_drive_low) rel_cnt <= rel_cnt + 1;
    else rel_cnt <= 0;
  end
  assign slave_low = (busy && !bus_drive_low && rel_cnt >= ps && rel_cnt < pe);
  assign bus_in = !(bus_drive_low || slave_low || force_low);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int m_busy, m_low, m_clash, m_nopull, m_done_w;

  // Runs one sequence; ign_at >= 0 raises start again at that busy cycle
  task automatic run_seq(input int p_s, input int p_e, input int ign_at);
    int n;
    ps = p_s; pe = p_e;
    m_busy = 0; m_low = 0; m_clash = 0; m_nopull = 0; m_done_w = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      if (busy) m_busy++;
      if (bus_drive_low) m_low++;
      if (bus_drive_low && pullup_en) m_clash++;
      if (!bus_drive_low && !pullup_en) m_nopull++;
      @(negedge clk);
      start = (n + 1 == ign_at);
      n++;
    end
    start = 1'b0;
    while (done) begin
      m_done_w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    chk(!busy && !done && !bus_drive_low, "R9 idle outputs", {busy, done, bus_drive_low}, 0);
    chk(!presence && !bus_short, "R9 flags", {presence, bus_short}, 0);
    chk(pullup_en, "R9 pullup", pullup_en, 1);
  endtask

  task automatic t_present();
    run_seq(30*CPU, 200*CPU, -1);
    chk(m_low == LOW_CYC, "R1 drive length", m_low, LOW_CYC);
    chk(m_busy == BUSY_CYC, "R5 busy length", m_busy, BUSY_CYC);
    chk(m_done_w == 1, "R5 done width", m_done_w, 1);
    chk(m_clash == 0, "R2 drive with pullup", m_clash, 0);
    chk(m_nopull == 0, "R2 pullup released", m_nopull, 0);
    chk(presence == 1'b1, "R3 presence seen", presence, 1);
    chk(bus_short == 1'b0, "R4 no short", bus_short, 0);
  endtask

  task automatic t_absent();
    run_seq(0, 0, -1);
    chk(presence == 1'b0, "R3 no slave", presence, 0);
    chk(bus_short == 1'b0, "R4 no slave short", bus_short, 0);
  endtask

  task automatic t_early_pulse();
    run_seq(5*CPU, 55*CPU, -1);
    chk(presence == 1'b0, "R3 pulse before sample", presence, 0);
  endtask

  task automatic t_late_pulse();
    run_seq(75*CPU, 300*CPU, -1);
    chk(presence == 1'b0, "R3 pulse after sample", presence, 0);
    chk(bus_short == 1'b0, "R4 late pulse released", bus_short, 0);
  endtask

  task automatic t_stuck_low();
    run_seq(0, 100000, -1);
    chk(presence == 1'b1, "R3 stuck line presence", presence, 1);
    chk(bus_short == 1'b1, "R4 stuck line short", bus_short, 1);
  endtask

  task automatic t_window_edge();
    // ends just after the window: short; ends well before: no short
    run_seq(30*CPU, (WINU+5)*CPU, -1);
    chk(bus_short == 1'b1, "R4 low past window", bus_short, 1);
    run_seq(30*CPU, (WINU-10)*CPU, -1);
    chk(bus_short == 1'b0, "R4 released before end", bus_short, 0);
  endtask

  task automatic t_start_ignored();
    run_seq(30*CPU, 200*CPU, (LOWU+100)*CPU);
    chk(m_busy == BUSY_CYC, "R7 busy length with start", m_busy, BUSY_CYC);
    chk(m_low == LOW_CYC, "R7 drive length with start", m_low, LOW_CYC);
    run_seq(0, 0, 50*CPU);
    chk(m_low == LOW_CYC, "R7 start during drive", m_low, LOW_CYC);
    chk(presence == 1'b0, "R7 result unchanged", presence, 0);
  endtask

  task automatic t_hold_clear();
    run_seq(0, 100000, -1);
    force_low = 1'b1;
    repeat (40) @(negedge clk);
    chk(presence && bus_short, "R6 hold while line low", {presence, bus_short}, 3);
    force_low = 1'b0;
    repeat (40) @(negedge clk);
    chk(presence && bus_short, "R6 hold after release", {presence, bus_short}, 3);
    chk(!busy && !bus_drive_low, "R6 idle unaffected", {busy, bus_drive_low}, 0);
    ps = 0; pe = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!presence && !bus_short, "R8 flags cleared", {presence, bus_short}, 0);
    chk(busy && bus_drive_low, "R1 drive starts", {busy, bus_drive_low}, 3);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_present();
    t_absent();
    t_early_pulse();
    t_late_pulse();
    t_stuck_low();
    t_window_edge();
    t_start_ignored();
    t_hold_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule